// File: doc/BRIEF.md
# Page Permission Fault Checker

This block sits behind a two-level page table walker and decides whether a memory access may go ahead once the walk has ended. The walker hands over three things: whether a leaf entry was found, the flag bits of that entry, and the access kind (fetch, load or store). Alongside these come the translation-enable flag and the machine status fields that change the permission rules: make-executable-readable, supervisor-user-access, modify-privilege and previous-privilege. From these the block produces a fault flag, the page fault exception cause and the faulting virtual address.

The decision logic is purely combinational. Its result is captured in an output register on the cycle the walker raises its done strobe. The registered result stays in place until the next strobe, and a one-cycle valid pulse marks each new result. Delivering the trap to the hart, and any access fault that comes from physical memory attributes or protection, are handled elsewhere.

Top module: `pgperm_chk`

## Requirements
- R1: While rst_ni is low, valid_o, fault_o, cause_o and fault_va_o are all zero.
- R2: A done_i sampled high at a rising edge drives valid_o high for exactly the following cycle, and the new result appears on fault_o, cause_o and fault_va_o in that same cycle. When done_i is low at an edge, valid_o is low after it and the other three outputs hold their values.
- R3: When xlate_en_i is low (bare mode), no fault is reported, whatever the other inputs are.
- R4: With translation on and leaf_found_i low, the access faults.
- R5: With translation on, a leaf entry whose valid bit (bit 0 of pte_perm_i) is 0 faults. So does a leaf entry that has its write bit (bit 2) set while its read bit (bit 1) is clear.
- R6: With translation on, a fetch (acc_i = 0) faults when the execute bit (bit 3) is 0.
- R7: With translation on, a load (acc_i = 1) is allowed when the read bit is 1, or when mxr_i is 1 and the execute bit is 1. Otherwise the load faults.
- R8: With translation on, a store (acc_i = 2) faults when the write bit is 0.
- R9: With translation on, mprv_i = 1 and mpp_i = 2'b01, an access of any kind to a page whose user bit (bit 4) is 1 faults unless sum_i is 1.
- R10: On a fault, cause_o is 12 for a fetch, 13 for a load and 15 for a store. When there is no fault, cause_o is 0.
- R11: On a fault, fault_va_o carries the vaddr_i that was sampled with the done strobe. When there is no fault, fault_va_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | Walker done strobe; captures the decision |
| xlate_en_i | input | 1 | Translation enabled (low means bare mode) |
| leaf_found_i | input | 1 | The walk ended on a leaf entry |
| pte_perm_i | input | 5 | Leaf flag bits {U,X,W,R,V}, with V in bit 0 |
| acc_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| vaddr_i | input | VA_W | Virtual address of the access |
| mxr_i | input | 1 | Make-executable-readable status bit |
| sum_i | input | 1 | Supervisor user-memory access status bit |
| mprv_i | input | 1 | Modify-privilege status bit |
| mpp_i | input | 2 | Previous privilege field (01 is supervisor) |
| valid_o | output | 1 | One-cycle pulse when a new result is registered |
| fault_o | output | 1 | Registered page fault flag |
| cause_o | output | 4 | Registered exception cause (0 when no fault) |
| fault_va_o | output | VA_W | Registered faulting virtual address (0 when no fault) |

## Verification
The assertions assume that acc_i never carries the reserved code 3 while done_i is high. One assertion states this assumption, and the stimulus draws access kinds only from 0 to 2. They also assume that every input is held steady around the edge at which done_i is sampled. The bench changes inputs only on falling edges, and it fires back-to-back strobes, long idle gaps and random flag and status combinations, so that the hold behaviour and each permission rule are both reached.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  localparam int PERM_W = 5;
  localparam int CAUSE_W = 4;

  localparam logic [1:0] MPP_SUPER = 2'b01;

  localparam logic [CAUSE_W-1:0] CAUSE_FETCH_PF = 4'd12;
  localparam logic [CAUSE_W-1:0] CAUSE_LOAD_PF  = 4'd13;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE_PF = 4'd15;

  // field order matches the leaf entry flag layout
  typedef struct packed {
    logic usr;
    logic ex;
    logic wr;
    logic rd;
    logic vld;
  } perm_t;
endpackage

// File: rtl/pgperm_pte_eval.sv
module pgperm_pte_eval
  import pgperm_pkg::*;
(
  input  perm_t perm_i,
  input  acc_e  acc_i,
  input  logic  mxr_i,
  output logic  fault_o
);
  logic malformed;
  logic kind_deny;

  assign malformed = !perm_i.vld || (perm_i.wr && !perm_i.rd);

  always_comb begin
    unique case (acc_i)
      ACC_FETCH: kind_deny = !perm_i.ex;
      ACC_STORE: kind_deny = !perm_i.wr;
      default:   kind_deny = !(perm_i.rd || (mxr_i && perm_i.ex));
    endcase
  end

  assign fault_o = malformed || kind_deny;
endmodule

// File: rtl/pgperm_priv_eval.sv
module pgperm_priv_eval
  import pgperm_pkg::*;
(
  input  logic       usr_page_i,
  input  logic       mprv_i,
  input  logic [1:0] mpp_i,
  input  logic       sum_i,
  output logic       fault_o
);
  logic super_eff;

  assign super_eff = mprv_i && (mpp_i == MPP_SUPER);
  assign fault_o   = super_eff && usr_page_i && !sum_i;
endmodule

// File: rtl/pgperm_cause_sel.sv
module pgperm_cause_sel
  import pgperm_pkg::*;
(
  input  acc_e               acc_i,
  output logic [CAUSE_W-1:0] cause_o
);
  always_comb begin
    unique case (acc_i)
      ACC_FETCH: cause_o = CAUSE_FETCH_PF;
      ACC_STORE: cause_o = CAUSE_STORE_PF;
      default:   cause_o = CAUSE_LOAD_PF;
    endcase
  end
endmodule

// File: rtl/pgperm_chk.sv
module pgperm_chk
  import pgperm_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               done_i,
  input  logic               xlate_en_i,
  input  logic               leaf_found_i,
  input  logic [PERM_W-1:0]  pte_perm_i,
  input  logic [1:0]         acc_i,
  input  logic [VA_W-1:0]    vaddr_i,
  input  logic               mxr_i,
  input  logic               sum_i,
  input  logic               mprv_i,
  input  logic [1:0]         mpp_i,
  output logic               valid_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [VA_W-1:0]    fault_va_o
);
  acc_e               acc;
  perm_t              perm;
  logic               pte_fault;
  logic               priv_fault;
  logic               fault_d;
  logic [CAUSE_W-1:0] cause_sel;

  logic               valid_q;
  logic               fault_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [VA_W-1:0]    va_q;

  assign acc  = acc_e'(acc_i);
  assign perm = perm_t'(pte_perm_i);

  pgperm_pte_eval u_pte_eval (
    .perm_i (perm),
    .acc_i  (acc),
    .mxr_i  (mxr_i),
    .fault_o(pte_fault)
  );

  pgperm_priv_eval u_priv_eval (
    .usr_page_i(perm.usr),
    .mprv_i    (mprv_i),
    .mpp_i     (mpp_i),
    .sum_i     (sum_i),
    .fault_o   (priv_fault)
  );

  pgperm_cause_sel u_cause_sel (
    .acc_i  (acc),
    .cause_o(cause_sel)
  );

  // entry flags only matter once a leaf exists
  assign fault_d = xlate_en_i && (!leaf_found_i || pte_fault || priv_fault);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      cause_q <= '0;
      va_q    <= '0;
    end else begin
      valid_q <= done_i;
      if (done_i) begin
        fault_q <= fault_d;
        cause_q <= fault_d ? cause_sel : '0;
        va_q    <= fault_d ? vaddr_i : '0;
      end
    end
  end

  assign valid_o    = valid_q;
  assign fault_o    = fault_q;
  assign cause_o    = cause_q;
  assign fault_va_o = va_q;

  // input assumption: reserved access code never strobed
  acc_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> acc_i != 2'b11);

  // R2
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> valid_o);

  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> !valid_o);

  // R2
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(fault_o) && $stable(cause_o) && $stable(fault_va_o));

  // R3
  bare_no_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !xlate_en_i |=> !fault_o);

  // R4
  no_leaf_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && xlate_en_i && !leaf_found_i |=> fault_o);

  // R10
  store_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && xlate_en_i && !leaf_found_i && acc_i == 2'd2 |=> cause_o == 4'd15);

  // R10
  clean_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> cause_o == '0);

  // R11
  fault_va_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (fault_o ? fault_va_o == $past(vaddr_i) : fault_va_o == '0));
endmodule

// File: tb/pgperm_chk_bench.sv
`timescale 1ns/1ps
module pgperm_chk_bench;
  localparam int VA_W = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            done_i = 1'b0;
  logic            xlate_en_i = 1'b0;
  logic            leaf_found_i = 1'b0;
  logic [4:0]      pte_perm_i = '0;
  logic [1:0]      acc_i = '0;
  logic [VA_W-1:0] vaddr_i = '0;
  logic            mxr_i = 1'b0;
  logic            sum_i = 1'b0;
  logic            mprv_i = 1'b0;
  logic [1:0]      mpp_i = '0;
  logic            valid_o;
  logic            fault_o;
  logic [3:0]      cause_o;
  logic [VA_W-1:0] fault_va_o;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    finished = 0;
  bit    exp_valid = 0;
  bit    exp_fault = 0;
  int    exp_cause = 0;
  logic [VA_W-1:0] exp_va = '0;
  string exp_tag = "R1";

  always #2.5 clk_i = ~clk_i;

  pgperm_chk #(.VA_W(VA_W)) u_pgperm_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done_i), .xlate_en_i(xlate_en_i),
    .leaf_found_i(leaf_found_i), .pte_perm_i(pte_perm_i), .acc_i(acc_i),
    .vaddr_i(vaddr_i), .mxr_i(mxr_i), .sum_i(sum_i), .mprv_i(mprv_i),
    .mpp_i(mpp_i), .valid_o(valid_o), .fault_o(fault_o), .cause_o(cause_o),
    .fault_va_o(fault_va_o)
  );

  // behavioural reference of the permission rules
  function automatic void ref_rule(input bit xe, input bit leaf, input bit [4:0] p,
                                   input int acc, input bit mxr, input bit sum,
                                   input bit mprv, input bit [1:0] mpp,
                                   output bit f, output string tag);
    bit v = p[0], r = p[1], w = p[2], x = p[3], u = p[4];
    f = 1; tag = "R3";
    if (!xe) begin f = 0; tag = "R3"; return; end
    if (!leaf) begin tag = "R4"; return; end
    if (!v || (w && !r)) begin tag = "R5"; return; end
    if (acc == 0 && !x) begin tag = "R6"; return; end
    if (acc == 1 && !(r || (mxr && x))) begin tag = "R7"; return; end
    if (acc == 2 && !w) begin tag = "R8"; return; end
    if (mprv && mpp == 2'b01 && u && !sum) begin tag = "R9"; return; end
    f = 0;
    tag = (acc == 0) ? "R6" : (acc == 1) ? "R7" : "R8";
  endfunction

  task automatic compare(input bit in_rst);
    string t;
    bit bad = 0;
    n_vec++;
    t = in_rst ? "R1" : "R2";
    if (valid_o !== exp_valid) begin
      bad = 1;
      $display("FAIL %s valid_o actual=%0b expected=%0b", t, valid_o, exp_valid);
    end
    if (fault_o !== exp_fault) begin
      bad = 1;
      $display("FAIL %s fault_o actual=%0b expected=%0b", in_rst ? "R1" : exp_tag, fault_o, exp_fault);
    end
    if (cause_o !== exp_cause[3:0]) begin
      bad = 1;
      $display("FAIL %s cause_o actual=%0d expected=%0d", in_rst ? "R1" : "R10", cause_o, exp_cause);
    end
    if (fault_va_o !== exp_va) begin
      bad = 1;
      $display("FAIL %s fault_va_o actual=%h expected=%h", in_rst ? "R1" : "R11", fault_va_o, exp_va);
    end
    if (bad) n_bad++;
  endtask

  // compare on each falling edge, then drive the next inputs
  task automatic step(input bit dn, input bit xe, input bit leaf, input bit [4:0] p,
                      input int acc, input logic [VA_W-1:0] va, input bit mxr,
                      input bit sum, input bit mprv, input bit [1:0] mpp);
    bit f;
    string tag;
    @(negedge clk_i);
    compare(0);
    done_i = dn; xlate_en_i = xe; leaf_found_i = leaf; pte_perm_i = p;
    acc_i = acc[1:0]; vaddr_i = va; mxr_i = mxr; sum_i = sum; mprv_i = mprv; mpp_i = mpp;
    exp_valid = dn;
    if (dn) begin
      ref_rule(xe, leaf, p, acc, mxr, sum, mprv, mpp, f, tag);
      exp_fault = f;
      exp_tag = tag;
      exp_cause = !f ? 0 : (acc == 0) ? 12 : (acc == 1) ? 13 : 15;
      exp_va = f ? va : '0;
    end
  endtask

  initial begin
    // R1: outputs cleared while in reset
    repeat (3) begin
      @(negedge clk_i);
      compare(1);
    end
    rst_ni = 1'b1;
    // R3: bare mode, even with a broken entry
    step(1, 0, 0, 5'b00000, 2, 32'h1000_0004, 0, 0, 0, 2'b00);
    // R4: no leaf found, fetch
    step(1, 1, 0, 5'b01011, 0, 32'hdead_beef, 0, 0, 0, 2'b00);
    // R2: idle cycles must hold the result
    step(0, 0, 1, 5'b11111, 1, 32'h0, 0, 0, 0, 2'b00);
    step(0, 1, 0, 5'b00000, 2, 32'h5, 0, 0, 0, 2'b00);
    // R5: valid bit clear, load
    step(1, 1, 1, 5'b01110, 1, 32'h0000_2000, 1, 0, 0, 2'b00);
    // R5: write without read, store
    step(1, 1, 1, 5'b01101, 2, 32'h0000_3000, 0, 0, 0, 2'b00);
    // R6: fetch from non-executable page
    step(1, 1, 1, 5'b00011, 0, 32'h0040_0000, 0, 0, 0, 2'b00);
    // R6: fetch allowed
    step(1, 1, 1, 5'b01001, 0, 32'h0040_0010, 0, 0, 0, 2'b00);
    // R7: execute-only load faults without mxr, passes with it
    step(1, 1, 1, 5'b01001, 1, 32'h0050_0000, 0, 0, 0, 2'b00);
    step(1, 1, 1, 5'b01001, 1, 32'h0050_0004, 1, 0, 0, 2'b00);
    // R8: store to read-only page, then writable page
    step(1, 1, 1, 5'b00011, 2, 32'h0060_0000, 0, 0, 0, 2'b00);
    step(1, 1, 1, 5'b00111, 2, 32'h0060_0008, 0, 0, 0, 2'b00);
    // R9: supervisor via mprv on user page, without then with sum
    step(1, 1, 1, 5'b10011, 1, 32'h0070_0000, 0, 0, 1, 2'b01);
    step(1, 1, 1, 5'b10011, 1, 32'h0070_0004, 0, 1, 1, 2'b01);
    // R9: mpp not supervisor, no fault
    step(1, 1, 1, 5'b10111, 2, 32'h0070_0008, 0, 0, 1, 2'b11);
    // R10: user-page fetch cause 12 under mprv
    step(1, 1, 1, 5'b11001, 0, 32'h0080_0000, 0, 0, 1, 2'b01);
    step(0, 0, 0, 5'b00000, 0, 32'h0, 0, 0, 0, 2'b00);
    // random sweep covering R2..R11
    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 9) < 7, $urandom_range(0, 5) != 0, $urandom_range(0, 5) != 0,
           5'($urandom), $urandom_range(0, 2), $urandom, 1'($urandom), 1'($urandom),
           1'($urandom), 2'($urandom));
    end
    step(0, 0, 0, 5'b00000, 0, 32'h0, 0, 0, 0, 2'b00);
    @(negedge clk_i);
    compare(0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule